// File: doc/BRIEF.md
# Shift configuration decoder

This block expands one compact configuration word into every control vector needed by a 64-bit shift datapath that works at several granularities. The datapath is built from eight 8-bit lane shifters, three levels of swap switches that merge neighbouring halves into wider words, and a final AND mask that turns rotations into logical shifts. A granularity field splits the 64 bits into aligned segments of 64, 32, 16 or 8 bits. Each lane carries a 9-bit operation word. A multi-lane segment takes its operation from its most significant lane.

The decoder is purely combinational. It turns right operations into the equivalent left rotation and works out which segment owns each lane. It then produces the lane shifter amounts, the thermometer-coded switch words for each merge level and the logical-shift mask. A separate control field for the linear combiner stage is passed through unchanged.

Top module: `shift_cfg_decoder`

## Requirements
- R1: Operation word `op_i[i]` belongs to lane i, where lane 0 holds data bits 7:0. In each word, bit 8 set means a logical shift and clear means a rotation. Bit 7 set means left and clear means right. Bits 6:0 hold the amount.
- R2: The granularity field is resolved coarsest first. Bit 14 claims the full word. Bits 13:12 claim the 32-bit halves, with bit 12 for the lower half. Bits 11:8 claim the 16-bit quarters and bits 7:0 claim single lanes. A clear bit defers the decision to the finer level. A lane that no bit claims is idle: its shifter control is 0, its mask bits are 1 and no switch above it is set.
- R3: A segment of width W takes its operation from its most significant lane. Only the amount modulo W takes effect.
- R4: A right amount r becomes the left amount k = (W − r mod W) mod W. Every lane of the segment receives k[2:0] on `bsh_o`.
- R5: Switch level h merges halves of H = 8·2^h bits. Bits [m·H+H−1 : m·H] of `sw_o[h]` serve merge m, counted from lane 0. The word has its low (k mod H) bits set, and the whole word is inverted when the bit of weight H in k is set.
- R6: Every bit of a merge that does not lie inside a segment wider than 2H−1 bits is 0.
- R7: A logical left shift clears the lowest r bits of its segment, and a logical right shift clears the highest r bits. Rotations and idle lanes give an all-ones mask.
- R8: An effective amount of zero gives lane controls of 0, no switch set and an all-ones mask, in either direction and for either kind of operation.
- R9: `lin_o` always equals `lin_i`.
- R10: The outputs follow the inputs with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| gran_i | input | 15 | Granularity enables, coarsest level in the top bit |
| op_i | input | 8x9 | Per-lane operation words |
| lin_i | input | 15 | Linear combiner control field |
| bsh_o | output | 8x3 | Left rotate amount for each lane shifter |
| sw_o | output | 3x32 | Switch words, one per merge level |
| mask_o | output | 64 | AND mask applied after the switches |
| lin_o | output | 15 | Copy of the linear combiner control field |

## Verification
The assertions check only when every input bit is known, because the decoder has no reset and its inputs start undefined. Their conditions cover configurations whose result is fixed regardless of the remaining fields. Examples are an empty granularity field, full-width mode with a zero amount, and all-rotate operation words. The stimulus always drives every field to a defined value. It deliberately places non-zero, logical-shift words in lanes that do not govern a segment, so that any wrong choice of governing lane shows up at the outputs.

// File: rtl/shift_cfg_pkg.sv
package shift_cfg_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = 8;
    localparam int AMT_W  = 7;
    localparam int LIN_W  = 15;
    localparam int OP_W   = AMT_W + 2;
    localparam int LVLS   = $clog2(LANES);
    localparam int LVL_W  = $clog2(LVLS + 1);
    localparam int IDX_W  = $clog2(LANES);
    localparam int LSH_W  = $clog2(LANE_W);
    localparam int GRAN_W = 2 * LANES - 1;
    localparam int SW_W   = LANES * LANE_W / 2;
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic             logical;
        logic             left;
        logic [AMT_W-1:0] amt;
    } lane_op_t;

    typedef struct packed {
        logic             act;
        logic [LVL_W-1:0] lvl;
        logic [IDX_W-1:0] gov;
    } seg_t;

    // Position of the enable bit owning a lane at a given level (0 = single lane).
    function automatic int gran_bit(input int lvl, input int lane);
        return 2 * LANES - 2 * (LANES >> lvl) + (lane >> lvl);
    endfunction

    // Amount bits that stay meaningful inside a segment of the given level.
    function automatic logic [AMT_W-1:0] seg_keep(input logic [LVL_W-1:0] lvl);
        return AMT_W'((LANE_W << lvl) - 1);
    endfunction
endpackage

// File: rtl/scd_seg_resolve.sv
module scd_seg_resolve
    import shift_cfg_pkg::*;
(
    input  logic [GRAN_W-1:0]   gran_i,
    output seg_t [LANES-1:0]    seg_o
);
    always_comb begin
        logic hit;
        for (int i = 0; i < LANES; i++) begin
            seg_o[i] = '0;
            hit = 1'b0;
            for (int l = LVLS; l >= 0; l--) begin
                if (!hit && gran_i[gran_bit(l, i)]) begin
                    hit = 1'b1;
                    seg_o[i].act = 1'b1;
                    seg_o[i].lvl = LVL_W'(l);
                    seg_o[i].gov = IDX_W'(((((i >> l) + 1) << l)) - 1);
                end
            end
        end
    end
endmodule

// File: rtl/scd_norm.sv
module scd_norm
    import shift_cfg_pkg::*;
(
    input  lane_op_t          op_i,
    output logic [AMT_W-1:0]  left_amt_o
);
    // Right by r equals left by -r modulo any power-of-two width.
    assign left_amt_o = op_i.left ? op_i.amt : (~op_i.amt) + AMT_W'(1);
endmodule

// File: rtl/scd_switch_word.sv
module scd_switch_word
    import shift_cfg_pkg::*;
#(
    parameter int H_LOG = 0
) (
    input  logic                          on_i,
    input  logic [AMT_W-1:0]              k_i,
    output logic [(LANE_W << H_LOG)-1:0]  sw_o
);
    localparam int HALF = LANE_W << H_LOG;
    localparam int WBIT = LSH_W + H_LOG;

    always_comb begin
        int kv;
        int part;
        logic flip;
        kv   = int'(k_i);
        part = kv & (HALF - 1);
        flip = kv[WBIT];
        for (int j = 0; j < HALF; j++) begin
            sw_o[j] = on_i & ((j < part) ^ flip);
        end
    end
endmodule

// File: rtl/scd_mask_lane.sv
module scd_mask_lane
    import shift_cfg_pkg::*;
#(
    parameter int IDX = 0
) (
    input  seg_t               seg_i,
    input  logic               logical_i,
    input  logic               left_i,
    input  logic [AMT_W-1:0]   k_i,
    output logic [LANE_W-1:0]  mask_o
);
    always_comb begin
        int k;
        int lo;
        int p;
        k  = int'(k_i);
        lo = int'(seg_i.gov) - (1 << seg_i.lvl) + 1;
        for (int b = 0; b < LANE_W; b++) begin
            p = (IDX - lo) * LANE_W + b;
            if (!seg_i.act || !logical_i) begin
                mask_o[b] = 1'b1;
            end else if (left_i) begin
                mask_o[b] = (p >= k);
            end else begin
                // right by r == left by k = W-r: the kept bits are those below k
                mask_o[b] = (k == 0) || (p < k);
            end
        end
    end
endmodule

// File: rtl/shift_cfg_decoder.sv
module shift_cfg_decoder
    import shift_cfg_pkg::*;
(
    input  logic [GRAN_W-1:0]           gran_i,
    input  logic [LANES-1:0][OP_W-1:0]  op_i,
    input  logic [LIN_W-1:0]            lin_i,
    output logic [LANES-1:0][LSH_W-1:0] bsh_o,
    output logic [LVLS-1:0][SW_W-1:0]   sw_o,
    output logic [DATA_W-1:0]           mask_o,
    output logic [LIN_W-1:0]            lin_o
);
    lane_op_t [LANES-1:0]            ops;
    seg_t     [LANES-1:0]            seg;
    logic     [LANES-1:0][AMT_W-1:0] norm;
    logic     [LANES-1:0][AMT_W-1:0] eff;

    assign ops   = op_i;
    assign lin_o = lin_i;

    scd_seg_resolve u_res (.gran_i(gran_i), .seg_o(seg));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic gov_logical;
        logic gov_left;

        scd_norm u_norm (.op_i(ops[i]), .left_amt_o(norm[i]));

        assign eff[i]      = norm[seg[i].gov] & seg_keep(seg[i].lvl);
        assign bsh_o[i]    = seg[i].act ? eff[i][LSH_W-1:0] : '0;
        assign gov_logical = ops[seg[i].gov].logical;
        assign gov_left    = ops[seg[i].gov].left;

        scd_mask_lane #(.IDX(i)) u_mask (
            .seg_i     (seg[i]),
            .logical_i (gov_logical),
            .left_i    (gov_left),
            .k_i       (eff[i]),
            .mask_o    (mask_o[i*LANE_W +: LANE_W])
        );
    end

    for (genvar h = 0; h < LVLS; h++) begin : g_lvl
        localparam int HALF   = LANE_W << h;
        localparam int SPAN   = 2 << h;
        localparam int MERGES = SW_W / HALF;
        for (genvar m = 0; m < MERGES; m++) begin : g_merge
            localparam int TOP = (m + 1) * SPAN - 1;
            logic on;
            assign on = seg[TOP].act && (seg[TOP].lvl > LVL_W'(h));
            scd_switch_word #(.H_LOG(h)) u_sw (
                .on_i (on),
                .k_i  (eff[TOP]),
                .sw_o (sw_o[h][m*HALF +: HALF])
            );
        end
    end
endmodule

// File: rtl/shift_cfg_checker.sv
module shift_cfg_checker
    import shift_cfg_pkg::*;
(
    input logic [GRAN_W-1:0]           gran_i,
    input logic [LANES-1:0][OP_W-1:0]  op_i,
    input logic [LIN_W-1:0]            lin_i,
    input logic [LANES-1:0][LSH_W-1:0] bsh_o,
    input logic [LVLS-1:0][SW_W-1:0]   sw_o,
    input logic [DATA_W-1:0]           mask_o,
    input logic [LIN_W-1:0]            lin_o
);
    always_comb begin
        logic rot_only;
        logic uniform;
        logic same_ops;
        rot_only = 1'b1;
        uniform  = 1'b1;
        same_ops = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            rot_only = rot_only & ~op_i[i][OP_W-1];
            uniform  = uniform & (bsh_o[i] == bsh_o[LANES-1]);
            same_ops = same_ops & (op_i[i] == op_i[0]);
        end
        if (!$isunknown({gran_i, op_i, lin_i})) begin
            p_lin_pass_r9: assert (lin_o == lin_i)
                else $error("combiner field altered");
            if (gran_i == '0) begin
                p_idle_r2: assert (bsh_o == '0 && sw_o == '0 && &mask_o)
                    else $error("idle word produced controls");
            end
            if (rot_only) begin
                p_rot_mask_r7: assert (&mask_o)
                    else $error("rotation cleared mask bits");
            end
            if (gran_i[GRAN_W-1]) begin
                p_full_uniform_r4: assert (uniform)
                    else $error("lanes of one segment differ");
            end
            if (gran_i[GRAN_W-1] && op_i[LANES-1][AMT_W-1:0] == '0) begin
                p_zero_amt_r8: assert (sw_o == '0 && &mask_o)
                    else $error("zero amount produced controls");
            end
            if (!gran_i[GRAN_W-1]) begin
                p_top_level_r6: assert (sw_o[LVLS-1] == '0)
                    else $error("top switch level used below full width");
            end
            if (gran_i == GRAN_W'({LANES{1'b1}}) && same_ops) begin
                p_lane_equal_r3: assert (uniform)
                    else $error("equal lane words gave unequal controls");
            end
        end
    end
endmodule

bind shift_cfg_decoder shift_cfg_checker u_chk (
    .gran_i (gran_i),
    .op_i   (op_i),
    .lin_i  (lin_i),
    .bsh_o  (bsh_o),
    .sw_o   (sw_o),
    .mask_o (mask_o),
    .lin_o  (lin_o)
);

// File: tb/sim_shift_cfg_decoder.sv
module sim_shift_cfg_decoder;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    always #(PERIOD/2) clk = ~clk;

    logic [14:0]      gran;
    logic [7:0][8:0]  op;
    logic [14:0]      lin;
    logic [7:0][2:0]  bsh;
    logic [2:0][31:0] sw;
    logic [63:0]      mask;
    logic [14:0]      lino;

    int checks = 0;
    int errors = 0;

    shift_cfg_decoder u0 (
        .gran_i (gran), .op_i (op), .lin_i (lin),
        .bsh_o (bsh), .sw_o (sw), .mask_o (mask), .lin_o (lino)
    );

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [8:0] v);
        for (int i = 0; i < 8; i++) op[i] = v;
    endtask

    task automatic apply(input logic [14:0] g);
        @(posedge clk);
        gran = g;
        @(negedge clk);
    endtask

    task automatic t_idle();
        fill(9'h1FF);
        apply(15'h0000);
        chk("R2", "idle bsh", 128'(bsh), 128'h0);
        chk("R2", "idle sw", 128'(sw), 128'h0);
        chk("R2", "idle mask", 128'(mask), 128'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_full_left9();
        fill(9'h1FF);
        op[7] = 9'h089;
        apply(15'h4000);
        chk("R3", "full left9 bsh", 128'(bsh), 128'h249249);
        chk("R5", "full left9 sw", 128'(sw), 128'h000001FF_01FF01FF_FEFEFEFE);
        chk("R7", "full left9 mask", 128'(mask), 128'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_full_left35();
        fill(9'h1FF);
        op[7] = 9'h0A3;
        apply(15'h4000);
        chk("R4", "left35 bsh", 128'(bsh), 128'h6DB6DB);
        chk("R5", "left35 sw", 128'(sw), 128'hFFFFFFF8_00070007_07070707);
    endtask

    task automatic t_full_right3();
        fill(9'h1FF);
        op[7] = 9'h003;
        apply(15'h4000);
        chk("R4", "right3 bsh", 128'(bsh), 128'hB6DB6D);
        chk("R5", "right3 sw", 128'(sw), 128'hE0000000_E000E000_E0E0E0E0);
    endtask

    task automatic t_zero();
        fill(9'h1FF);
        op[7] = 9'h000;
        apply(15'h4000);
        chk("R8", "right0 bsh", 128'(bsh), 128'h0);
        chk("R8", "right0 sw", 128'(sw), 128'h0);
        op[7] = 9'h0C0;
        apply(15'h4000);
        chk("R3", "left64 wraps to 0 sw", 128'(sw), 128'h0);
        chk("R8", "left64 bsh", 128'(bsh), 128'h0);
        op[7] = 9'h100;
        apply(15'h4000);
        chk("R8", "logical right0 mask", 128'(mask), 128'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_mixed();
        fill(9'h1FF);
        op[7] = 9'h004;
        op[3] = 9'h088;
        op[1] = 9'h084;
        op[0] = 9'h084;
        apply(15'h2203);
        chk("R4", "mixed bsh", 128'(bsh), 128'h924024);
        chk("R6", "mixed sw", 128'(sw), 128'h00000000_F0000000_F0F0FF00);
        chk("R7", "mixed mask", 128'(mask), 128'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_logic_left5();
        fill(9'h000);
        op[7] = 9'h185;
        apply(15'h4000);
        chk("R1", "logical left5 mask", 128'(mask), 128'hFFFF_FFFF_FFFF_FFE0);
        chk("R7", "logical left5 bsh", 128'(bsh), 128'hB6DB6D);
        chk("R5", "logical left5 sw", 128'(sw), 128'h0000001F_001F001F_1F1F1F1F);
    endtask

    task automatic t_logic_right12();
        fill(9'h000);
        op[6] = 9'h1FF;
        op[7] = 9'h10C;
        apply(15'h083F);
        chk("R7", "logical right12 mask", 128'(mask), 128'h000F_FFFF_FFFF_FFFF);
        chk("R4", "logical right12 bsh", 128'(bsh), 128'h900000);
        chk("R6", "logical right12 sw", 128'(sw), 128'h00000000_00000000_0F000000);
    endtask

    task automatic t_lane_left11();
        fill(9'h1FF);
        op[2] = 9'h18B;
        apply(15'h0004);
        chk("R7", "lane2 left11 mask", 128'(mask), 128'hFFFF_FFFF_FFF8_FFFF);
        chk("R2", "lane2 bsh idle others", 128'(bsh), 128'h0000C0);
        chk("R6", "lane2 sw", 128'(sw), 128'h0);
    endtask

    task automatic t_priority();
        fill(9'h1FF);
        op[7] = 9'h089;
        apply(15'h7FFF);
        chk("R2", "priority bsh", 128'(bsh), 128'h249249);
        chk("R2", "priority sw", 128'(sw), 128'h000001FF_01FF01FF_FEFEFEFE);
    endtask

    task automatic t_comb_and_lin();
        fill(9'h000);
        lin = 15'h05A3;
        apply(15'h4000);
        chk("R9", "lin a", 128'(lino), 128'h05A3);
        lin = 15'h2A5C;
        op[7] = 9'h089;
        #1;
        chk("R9", "lin b", 128'(lino), 128'h2A5C);
        chk("R10", "no-clock update bsh", 128'(bsh), 128'h249249);
    endtask

    initial begin
        gran = '0;
        lin  = '0;
        fill(9'h000);
        t_idle();
        t_full_left9();
        t_full_left35();
        t_full_right3();
        t_zero();
        t_mixed();
        t_logic_left5();
        t_logic_right12();
        t_lane_left11();
        t_priority();
        t_comb_and_lin();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule